// File: doc/BRIEF.md
# Masked-Round Weighted Queue Scheduler with Strict-Priority Group

This block decides which queue of one output port may send its next packet. Up to eight queues are attached to the port. Each queue has a small configuration entry: a round-enable mask, a strict-priority membership flag, a flag marking the last queue attached to the port, and a flag marking the last queue of the strict-priority group. Software loads these entries through a single write port. Entries can be rewritten while traffic flows.

On each decision the block serves strict-priority queues first. Among the requesting strict-priority queues, the lowest index wins. When no strict-priority queue requests, a weighted queue is chosen. The mask of a weighted queue lists the rotating rounds (0 to 7) in which it may be served, so a queue with more mask bits set gets proportionally more service. Within a round, the search is round-robin and starts after the last weighted queue served. Rounds with no eligible requester are skipped within the same decision, so the block never spends an idle cycle while some round has an eligible queue. The recommended weight masks spread their set bits: 0x00, 0x01, 0x11, 0x49, 0x55, 0x57, 0x77, 0x7F and 0xFF stand for weights 0 to 8.

The grant is registered. It is held until the downstream logic pulses `sent`, and a fresh decision is taken in that same cycle.

Top module: `wq_sched`

## Requirements
- R1: After synchronous reset, `gnt_valid` is 0, `gnt_idx` is 0, and every configuration entry is cleared (mask 0, all flags 0). No request is granted until an entry is written.
- R2: A decision is taken in every cycle where no grant is held or `sent` is 1. Its result appears on `gnt_valid`/`gnt_idx` after the next rising edge. If no queue is eligible, `gnt_valid` goes to 0.
- R3: While `gnt_valid` is 1 and `sent` is 0, `gnt_valid` and `gnt_idx` stay unchanged whatever `req` does.
- R4: Any requesting strict-priority queue wins over every weighted queue. Among the strict-priority queues, the lowest index wins. Serving a strict-priority queue changes neither the round nor the round-robin pointer.
- R5: A queue is a strict-priority member only if its strict flag is set and it lies at or below the lowest index whose strict-group-last flag is set (if that flag is set nowhere, the strict flag alone decides). A queue with the strict flag set above that bound is scheduled as a weighted queue.
- R6: Queues with an index above the lowest index whose port-last flag is set are not attached and are never granted. If no port-last flag is set, all queues are attached.
- R7: A weighted queue is eligible in round k only when bit k of its mask is 1. A queue whose mask is 0 is never granted as a weighted queue.
- R8: Within a round, weighted queues are searched round-robin, starting at the index after the last weighted queue granted. After reset this pointer is the highest index, so the first search starts at queue 0.
- R9: The round starts at 0 after reset. After a weighted grant in round r, the next search starts in round r+1 modulo 8. A decision skips rounds with no eligible requester and still grants in the same cycle.
- R10: A configuration write with `cfg_we` at 1 takes effect for decisions from the following cycle on, including while grants are being issued. A grant that is already held is not altered by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one configuration entry |
| cfg_idx | input | 3 | Queue index of the entry written |
| cfg_mask | input | 8 | Round-enable mask, bit k = round k |
| cfg_static | input | 1 | Strict-priority membership flag |
| cfg_port_last | input | 1 | Marks this queue as the last one attached to the port |
| cfg_static_last | input | 1 | Marks this queue as the last one of the strict-priority group |
| req | input | 8 | Per-queue request, bit i = queue i has a packet |
| sent | input | 1 | Grant consumed; allows the next decision |
| gnt_valid | output | 1 | A grant is held |
| gnt_idx | output | 3 | Index of the granted queue |

## Verification
Each grant result is due exactly one rising edge after the cycle whose inputs decided it. A write to a configuration entry first affects the decision in the following cycle. The bench carries a cycle-level reference of the rules above. For every cycle it drives, it pushes one expected grant state, computed from that cycle's inputs, into a scoreboard. A monitor pops one entry 1 ns after each rising edge and compares it with `gnt_valid`/`gnt_idx` (the index only when a grant is expected), so a result that comes early, late or held wrongly shows up in that cycle. The held-grant cycles, the skipped rounds, the bounds set by the tail flags and the rewrites made in mid-traffic are all covered by the same per-cycle comparison.

// File: rtl/wq_sched_pkg.sv
// Shared defaults and the per-queue flag record of the weighted queue scheduler.
package wq_sched_pkg;

    localparam int DEF_QUEUES = 8;
    localparam int DEF_ROUNDS = 8;

    // Flags stored with each queue entry next to its round mask.
    typedef struct packed {
        logic strict_member;  // queue asks for strict-priority service
        logic port_last;      // last queue attached to the port
        logic static_last;    // last queue of the strict-priority group
    } qflags_t;

endpackage

// File: rtl/wq_cfg_table.sv
// Per-queue configuration store.
// Holds one round mask and one flag record per queue, written one entry per cycle.
// Derives which queues are attached (up to the first port-last flag) and which
// are effective strict-priority members (strict flag, attached, and at or below
// the first strict-group-last flag).
// Assumes at most one write per cycle; a write is visible the cycle after.
module wq_cfg_table
    import wq_sched_pkg::*;
#(
    parameter int NQ = DEF_QUEUES,
    parameter int NR = DEF_ROUNDS,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [QW-1:0]    wr_idx,
    input  logic [NR-1:0]    wr_mask,
    input  qflags_t          wr_flags,
    output logic [NQ*NR-1:0] mask_flat,
    output logic [NQ-1:0]    attached,
    output logic [NQ-1:0]    strict
);

    logic [NR-1:0] mask_q  [NQ];
    qflags_t       flags_q [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_entry
        // Store or clear one queue entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[g]  <= '0;
                flags_q[g] <= '0;
            end else if (wr_en && wr_idx == QW'(g)) begin
                mask_q[g]  <= wr_mask;
                flags_q[g] <= wr_flags;
            end
        end
        assign mask_flat[g*NR +: NR] = mask_q[g];
    end

    // Derive attachment and strict membership from the tail flags as prefixes.
    always_comb begin
        logic port_seen;
        logic strict_seen;
        port_seen   = 1'b0;
        strict_seen = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            attached[i] = !port_seen;
            strict[i]   = flags_q[i].strict_member && !port_seen && !strict_seen;
            port_seen   = port_seen   | flags_q[i].port_last;
            strict_seen = strict_seen | flags_q[i].static_last;
        end
    end

endmodule

// File: rtl/wq_strict_pick.sv
// Fixed-priority picker for the strict-priority group.
// Returns the lowest-index candidate; found is low when no candidate is set.
module wq_strict_pick #(
    parameter int NQ = 8,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic [NQ-1:0] cand,
    output logic          found,
    output logic [QW-1:0] idx
);

    // Scan downward so the lowest set index is kept last.
    always_comb begin
        idx = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (cand[i]) idx = QW'(i);
        end
        found = |cand;
    end

endmodule

// File: rtl/wq_round_pick.sv
// Weighted picker over rotating rounds.
// Starting at the current round, finds the first round in which some candidate
// has its mask bit set, and within it the first candidate after the last one
// served (round-robin). All rounds are searched in one cycle, so empty rounds
// cost no time. Assumes NR >= 2.
module wq_round_pick #(
    parameter int NQ = 8,
    parameter int NR = 8,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int RW = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic [NQ*NR-1:0] mask_flat,
    input  logic [NQ-1:0]    cand,
    input  logic [RW-1:0]    round,
    input  logic [QW-1:0]    last,
    output logic             found,
    output logic [QW-1:0]    idx,
    output logic [RW-1:0]    hit_round
);

    // Two-level search: rounds outward from the current one, queues after the pointer.
    always_comb begin
        int r;
        int q;
        found     = 1'b0;
        idx       = '0;
        hit_round = '0;
        for (int off = 0; off < NR; off++) begin
            r = (int'(round) + off) % NR;
            for (int k = 1; k <= NQ; k++) begin
                q = (int'(last) + k) % NQ;
                if (!found && cand[q] && mask_flat[q*NR + r]) begin
                    found     = 1'b1;
                    idx       = QW'(q);
                    hit_round = RW'(r);
                end
            end
        end
    end

endmodule

// File: rtl/wq_sched.sv
// Queue scheduler for one output port.
// Strict-priority members are served first (lowest index wins); otherwise a
// weighted queue is picked by round mask and round-robin pointer. The grant is
// registered and held until sent; a new decision is taken whenever no grant is
// held or the held one is consumed in the current cycle.
// Assumes req is already qualified by the caller (queue really has a packet).
module wq_sched
    import wq_sched_pkg::*;
#(
    parameter int NQ = DEF_QUEUES,
    parameter int NR = DEF_ROUNDS,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int RW = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [QW-1:0] cfg_idx,
    input  logic [NR-1:0] cfg_mask,
    input  logic          cfg_static,
    input  logic          cfg_port_last,
    input  logic          cfg_static_last,
    input  logic [NQ-1:0] req,
    input  logic          sent,
    output logic          gnt_valid,
    output logic [QW-1:0] gnt_idx
);

    qflags_t          wr_flags;
    logic [NQ*NR-1:0] mask_flat;
    logic [NQ-1:0]    attached;
    logic [NQ-1:0]    strict;
    logic [NQ-1:0]    strict_cand;
    logic [NQ-1:0]    wt_cand;
    logic             st_found;
    logic [QW-1:0]    st_idx;
    logic             wt_found;
    logic [QW-1:0]    wt_idx;
    logic [RW-1:0]    wt_round;
    logic [RW-1:0]    round_q;
    logic [QW-1:0]    last_q;
    logic             gnt_valid_q;
    logic [QW-1:0]    gnt_idx_q;
    logic             slot_free;
    logic [RW-1:0]    round_next;

    // Pack the write-port flags into the stored record.
    always_comb begin
        wr_flags.strict_member = cfg_static;
        wr_flags.port_last     = cfg_port_last;
        wr_flags.static_last   = cfg_static_last;
    end

    wq_cfg_table #(.NQ(NQ), .NR(NR)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_mask   (cfg_mask),
        .wr_flags  (wr_flags),
        .mask_flat (mask_flat),
        .attached  (attached),
        .strict    (strict)
    );

    assign strict_cand = req & strict;
    assign wt_cand     = req & attached & ~strict;

    wq_strict_pick #(.NQ(NQ)) u_strict (
        .cand  (strict_cand),
        .found (st_found),
        .idx   (st_idx)
    );

    wq_round_pick #(.NQ(NQ), .NR(NR)) u_round (
        .mask_flat (mask_flat),
        .cand      (wt_cand),
        .round     (round_q),
        .last      (last_q),
        .found     (wt_found),
        .idx       (wt_idx),
        .hit_round (wt_round)
    );

    assign slot_free  = !gnt_valid_q || sent;
    assign round_next = (wt_round == RW'(NR - 1)) ? '0 : wt_round + 1'b1;

    // Register the decision and the weighted-search state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid_q <= 1'b0;
            gnt_idx_q   <= '0;
            round_q     <= '0;
            last_q      <= QW'(NQ - 1);
        end else if (slot_free) begin
            if (st_found) begin
                gnt_valid_q <= 1'b1;
                gnt_idx_q   <= st_idx;
            end else if (wt_found) begin
                gnt_valid_q <= 1'b1;
                gnt_idx_q   <= wt_idx;
                last_q      <= wt_idx;
                round_q     <= round_next;
            end else begin
                gnt_valid_q <= 1'b0;
            end
        end
    end

    assign gnt_valid = gnt_valid_q;
    assign gnt_idx   = gnt_idx_q;

endmodule

// File: rtl/wq_sched_chk.sv
// Property checker for wq_sched, attached with bind below.
// Keeps one-cycle copies of the decision inputs so each new grant can be
// related to the inputs that produced it.
module wq_sched_chk #(
    parameter int NQ = 8,
    parameter int NR = 8,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NQ-1:0]    req,
    input logic             sent,
    input logic             gnt_valid,
    input logic [QW-1:0]    gnt_idx,
    input logic [NQ-1:0]    strict,
    input logic [NQ*NR-1:0] mask_flat
);

    logic [NQ-1:0]    req_q;
    logic [NQ-1:0]    strict_q;
    logic [NQ*NR-1:0] mask_q;
    logic             free_q;

    // Capture the inputs of the decision taken at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= '0;
            strict_q <= '0;
            mask_q   <= '0;
            free_q   <= 1'b0;
        end else begin
            req_q    <= req;
            strict_q <= strict;
            mask_q   <= mask_flat;
            free_q   <= !gnt_valid || sent;
        end
    end

    // R3
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !sent) |=> (gnt_valid && $stable(gnt_idx)));

    // R2
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!gnt_valid || sent) && req == '0) |=> !gnt_valid);

    // R2
    grant_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_q && gnt_valid) |-> req_q[gnt_idx]);

    // R4
    strict_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_q && |(req_q & strict_q)) |->
            (gnt_valid && strict_q[gnt_idx] &&
             ((req_q & strict_q & ((NQ'(1) << gnt_idx) - NQ'(1))) == '0)));

    // R7
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_q && gnt_valid && !strict_q[gnt_idx]) |-> (mask_q[gnt_idx*NR +: NR] != '0));

endmodule

bind wq_sched wq_sched_chk #(.NQ(NQ), .NR(NR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .sent      (sent),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx),
    .strict    (strict),
    .mask_flat (mask_flat)
);

// File: tb/sim_wq_sched.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes one expected grant state per cycle
// from a reference of the requirements; a monitor compares after each edge.
module sim_wq_sched;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [7:0] cfg_mask = '0;
    logic       cfg_static = 1'b0;
    logic       cfg_port_last = 1'b0;
    logic       cfg_static_last = 1'b0;
    logic [7:0] req = '0;
    logic       sent = 1'b0;
    logic       gnt_valid;
    logic [2:0] gnt_idx;

    always #2.5 clk = ~clk;

    wq_sched u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_we          (cfg_we),
        .cfg_idx         (cfg_idx),
        .cfg_mask        (cfg_mask),
        .cfg_static      (cfg_static),
        .cfg_port_last   (cfg_port_last),
        .cfg_static_last (cfg_static_last),
        .req             (req),
        .sent            (sent),
        .gnt_valid       (gnt_valid),
        .gnt_idx         (gnt_idx)
    );

    typedef struct {
        bit    v;
        int    idx;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Reference state.
    bit [7:0] m_mask [8];
    bit       m_st [8];
    bit       m_pl [8];
    bit       m_sl [8];
    int       m_round;
    int       m_last;
    bit       m_valid;
    int       m_idx;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle of the reference: decision (R2..R9), then config write (R10).
    function automatic void model_step();
        bit att [8];
        bit stv [8];
        bit pseen;
        bit sseen;
        bit f;
        int q;
        int r;
        if (!m_valid || sent) begin
            pseen = 0;
            sseen = 0;
            for (int i = 0; i < 8; i++) begin
                att[i] = !pseen;
                stv[i] = m_st[i] && !pseen && !sseen;
                pseen  = pseen | m_pl[i];
                sseen  = sseen | m_sl[i];
            end
            f = 0;
            for (int i = 0; i < 8; i++)
                if (!f && stv[i] && req[i]) begin
                    f = 1;
                    m_idx = i;
                end
            for (int off = 0; off < 8; off++)
                for (int k = 1; k <= 8; k++) begin
                    q = (m_last + k) % 8;
                    r = (m_round + off) % 8;
                    if (!f && att[q] && !stv[q] && req[q] && m_mask[q][r]) begin
                        f = 1;
                        m_idx = q;
                        m_last = q;
                        m_round = (r + 1) % 8;
                    end
                end
            m_valid = f;
        end
        if (cfg_we) begin
            m_mask[cfg_idx] = cfg_mask;
            m_st[cfg_idx]   = cfg_static;
            m_pl[cfg_idx]   = cfg_port_last;
            m_sl[cfg_idx]   = cfg_static_last;
        end
    endfunction

    // Driver: push one expectation per cycle, then move to the next negedge.
    task automatic cyc(int n);
        exp_t e;
        for (int c = 0; c < n; c++) begin
            model_step();
            e.v   = m_valid;
            e.idx = m_idx;
            e.tag = cur_tag;
            sb.push_back(e);
            @(negedge clk);
        end
    endtask

    task automatic wr(int idx, bit [7:0] mask, bit st, bit pl, bit sl);
        cfg_we          = 1'b1;
        cfg_idx         = 3'(idx);
        cfg_mask        = mask;
        cfg_static      = st;
        cfg_port_last   = pl;
        cfg_static_last = sl;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    // Monitor: compare 1 ns after each rising edge.
    always begin
        exp_t e;
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            if (e.v)
                chk(gnt_valid && int'(gnt_idx) == e.idx, e.tag, "grant index",
                    gnt_valid ? int'(gnt_idx) : -1, e.idx);
            else
                chk(!gnt_valid, e.tag, "grant valid", int'(gnt_valid), 0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R2: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_mask[i] = '0; m_st[i] = 0; m_pl[i] = 0; m_sl[i] = 0;
        end
        m_round = 0;
        m_last  = 7;
        m_valid = 0;
        m_idx   = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk(gnt_valid == 1'b0, "R1", "reset valid", int'(gnt_valid), 0);
        chk(gnt_idx == 3'd0, "R1", "reset index", int'(gnt_idx), 0);
        rst_n = 1'b1;

        // R1: cleared table grants nothing
        cur_tag = "R1";
        req = 8'hFF;
        sent = 1'b1;
        cyc(3);

        // R10: load weighted entries; q3 ends the port, q4 unattached
        req = '0;
        sent = 1'b0;
        cur_tag = "R10";
        wr(0, 8'hFF, 0, 0, 0);
        wr(1, 8'h01, 0, 0, 0);
        wr(2, 8'h11, 0, 0, 0);
        wr(3, 8'h00, 0, 1, 0);
        wr(4, 8'hFF, 0, 0, 0);

        // R7 R8 R9: masked rounds, round-robin, consumed every cycle
        cur_tag = "R7 R8 R9";
        req = 8'h1F;
        sent = 1'b1;
        cyc(20);

        // R6 R7: only the zero-mask queue and the unattached queue request
        cur_tag = "R6";
        req = 8'h18;
        cyc(4);

        // R2: grant one edge after the request
        sent = 1'b0;
        req = '0;
        cur_tag = "R2";
        cyc(2);
        req = 8'h04;
        cyc(1);

        // R3: held while sent is low, whatever req does
        cur_tag = "R3";
        req = 8'h01;
        cyc(4);
        sent = 1'b1;
        cyc(1);
        sent = 1'b0;
        req = '0;
        cyc(2);
        // R2: consumed with nothing requesting drops the grant
        cur_tag = "R2";
        sent = 1'b1;
        cyc(2);

        // R10: strict group q0..q1, q2 flagged strict beyond the group end
        sent = 1'b0;
        cur_tag = "R10";
        wr(0, 8'hFF, 1, 0, 0);
        wr(1, 8'hFF, 1, 0, 1);
        wr(2, 8'h55, 1, 0, 0);
        wr(3, 8'h49, 0, 1, 0);

        // R4: strict members beat weighted, lowest index first
        cur_tag = "R4";
        sent = 1'b1;
        req = 8'h06;
        cyc(4);
        req = 8'h07;
        cyc(3);

        // R5: q2 scheduled by its mask as a weighted queue
        cur_tag = "R5";
        req = 8'h0C;
        cyc(8);

        // R10: rewrite a held queue's entry in mid-traffic
        cur_tag = "R10";
        sent = 1'b0;
        req = 8'h04;
        cyc(3);
        wr(2, 8'h00, 0, 0, 0);
        cyc(1);
        sent = 1'b1;
        cyc(3);

        // R9: single-round queue granted with no idle cycles
        cur_tag = "R9";
        sent = 1'b0;
        req = '0;
        wr(3, 8'h80, 0, 1, 0);
        req = 8'h08;
        cyc(1);
        sent = 1'b1;
        cyc(4);

        req = '0;
        sent = 1'b0;
        cyc(2);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule